// File: doc/BRIEF.md
# Receive IPv4 / TCP / UDP Checksum Checker

This block sits on the receive side of an Ethernet MAC. It watches each incoming frame as a byte stream, one byte per valid cycle, with start and end strobes. The frame check sequence has already been removed. While the bytes pass, the block parses the MAC header. It accepts at most one VLAN tag, and either a plain type field or an LLC/SNAP header. After that it walks the IPv4 header and the transport segment.

Two one's-complement sums are built on the fly. The first covers the IPv4 header. The second covers the TCP or UDP segment together with its pseudo header. Two cycles after the last byte, the block returns a one-cycle verdict. The verdict states which checks ran, whether every check that ran was good, and whether SNAP encapsulation was found. When a check fails, the block also pulses a discard request and a statistics-increment request for the surrounding logic.

A check runs only when the frame qualifies. Frames that do not qualify get no verdict on their checksums. They are never discarded by this block.

Top module: `rxc_csum_check`

## Requirements
- R1: After reset every output is low. For each frame, `stat_valid` pulses for exactly one cycle, two clock edges after the edge that accepts the byte carrying `in_eof`.
- R2: The IPv4 header check covers IHL×4 bytes as big-endian 16-bit words. It passes when the end-around-carry sum equals 0xFFFF. Any other sum sets `stat_bad`.
- R3: The TCP/UDP sum adds the source and destination addresses, the word 0x00‖protocol and the transport length (total length − IHL×4). It also adds every byte from the end of the IP header up to the IP total length. An odd final byte takes a zero low byte. Bytes beyond the total length are ignored. The check passes when the sum equals 0xFFFF.
- R4: Type 0x8100 at bytes 12–13 marks a VLAN tag. When bit 4 of the first tag byte (the CFI bit) is set, no check runs. When a second 0x8100 follows the tag, no check runs either.
- R5: A type/length value below 0x0600 must be followed by AA AA 03 00 00 00 and then the type 0x0800. On such a frame the checks may run and `stat_snap` is high. Any other LLC header stops all checks.
- R6: The header check runs only when all of these hold:
  - the frame type reaches 0x0800;
  - the version nibble is 4;
  - IHL is at least 5;
  - the total length is at least IHL×4;
  - the frame holds the whole header.
  Otherwise `stat_kind` is 00.
- R7: The transport check runs only when all of these hold:
  - the header check passed;
  - the MF flag (bit 5 of IP byte 6) is clear and the 13-bit fragment offset is zero;
  - the protocol is 6 (TCP) or 17 (UDP);
  - the total length exceeds IHL×4;
  - the frame holds the total length.
  Otherwise `stat_kind` is 01.
- R8: A UDP datagram whose checksum field (transport bytes 6–7) is 0x0000 is not checked. It reports kind 01 and is never bad.
- R9: `stat_kind` reports which checks ran: 00 none, 01 the IP header only, 10 IP and TCP, 11 IP and UDP. `stat_ok` is high when the kind is nonzero and no check failed. `stat_ok` and `stat_bad` are never high together.
- R10: A failed check raises `drop_pulse` and `cnt_inc_pulse` for the single cycle in which `stat_valid` is high. Neither pulses at any other time.
- R11: `cfg_enable` is sampled on the start byte only. A frame started while it is low reports every status bit low and raises no pulse, whatever `cfg_enable` does later in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Checking enabled for the frame that starts now |
| in_valid | input | 1 | A frame byte is present |
| in_sof | input | 1 | The present byte is the first byte of the frame |
| in_eof | input | 1 | The present byte is the last byte of the frame |
| in_data | input | 8 | Frame byte |
| stat_valid | output | 1 | The verdict outputs are valid this cycle |
| stat_ok | output | 1 | Every check that ran was good |
| stat_bad | output | 1 | At least one check that ran failed |
| stat_kind | output | 2 | Which checks ran (00, 01, 10, 11) |
| stat_snap | output | 1 | LLC/SNAP encapsulation was found |
| drop_pulse | output | 1 | Discard request for the frame |
| cnt_inc_pulse | output | 1 | Request to increment the checksum error counter |

## Verification
Clean TCP and UDP frames with even and odd segment lengths, and with trailing padding, show that the sum stops at the IP total length and pads the odd last byte. Frames with a corrupted header byte and frames with a corrupted segment byte separate a header failure (kind 01, bad) from a transport failure (kind 10/11, bad). The remaining patterns are:
- VLAN tags with and without CFI, double tags, good and bad LLC headers, and non-IP types, which test each encapsulation gate;
- fragments, short or long IHL, truncated frames, a zero UDP checksum and non-TCP/UDP protocols, which test the downgrade from kind 10/11 to 01 or 00;
- disabled frames, whose enable input toggles mid-frame, and gaps in `in_valid`, which show that only the start byte latches the enable and that stalls do not shift the parse.

// File: rtl/rxc_pkg.sv
// Shared constants, state encodings and one's-complement helper for the
// receive checksum checker.
package rxc_pkg;
    localparam logic [15:0] ETH_VLAN    = 16'h8100;
    localparam logic [15:0] ETH_IPV4    = 16'h0800;
    localparam logic [15:0] ETH_MINTYPE = 16'h0600;
    localparam logic [7:0]  PROTO_TCP   = 8'd6;
    localparam logic [7:0]  PROTO_UDP   = 8'd17;

    typedef enum logic [2:0] {
        L2_MAC, L2_TYPE_HI, L2_TYPE_LO, L2_TAG_HI,
        L2_TAG_LO, L2_LLC, L2_IP, L2_SKIP
    } l2_state_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_IPHDR = 2'b01,
        KIND_TCP   = 2'b10,
        KIND_UDP   = 2'b11
    } kind_e;

    // 16-bit one's-complement add with the carry folded back in.
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    // Expected LLC/SNAP header byte at position i (0..5).
    function automatic logic [7:0] snap_byte(input logic [2:0] i);
        if (i < 3'd2)       return 8'hAA;
        else if (i == 3'd2) return 8'h03;
        else                return 8'h00;
    endfunction
endpackage

// File: rtl/rxc_ocsum.sv
// One's-complement accumulator.
// Assumes: clr and add are never both high (the first byte of a frame never
// carries a word). The sum is held until the next clr.
module rxc_ocsum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] word,
    output logic [W-1:0] sum
);
    logic [W:0] raw;
    assign raw = {1'b0, sum} + {1'b0, word};

    // Accumulate one word per cycle with the end-around carry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sum <= '0;
        else if (add)      sum <= raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end

    // R2
    nonzero_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clr && word != '0) |=> (sum != '0));
endmodule

// File: rtl/rxc_l2_parse.sv
// MAC-header parser.
// Walks the destination/source addresses, at most one VLAN tag and an
// optional LLC/SNAP header, then flags every later byte as IPv4 when the type
// reaches 0x0800. Any other path parks in a skip state until the next start.
// Assumes: byte_sof comes with byte_vld on byte 0 of each frame.
module rxc_l2_parse (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic       byte_sof,
    input  logic [7:0] byte_d,
    output logic       ip_byte,
    output logic       snap_seen
);
    import rxc_pkg::*;

    l2_state_e   state;
    logic [3:0]  cnt;
    logic [7:0]  type_hi;
    logic        vlan_seen;
    logic [15:0] etype;

    assign etype   = {type_hi, byte_d};
    assign ip_byte = byte_vld && !byte_sof && (state == L2_IP);

    // Advance the header walk by one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= L2_SKIP;
            cnt       <= '0;
            type_hi   <= '0;
            vlan_seen <= 1'b0;
            snap_seen <= 1'b0;
        end else if (byte_vld && byte_sof) begin
            state     <= L2_MAC;
            cnt       <= 4'd1;
            vlan_seen <= 1'b0;
            snap_seen <= 1'b0;
        end else if (byte_vld) begin
            case (state)
                L2_MAC: begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd11) state <= L2_TYPE_HI;
                end
                L2_TYPE_HI: begin
                    type_hi <= byte_d;
                    state   <= L2_TYPE_LO;
                end
                L2_TYPE_LO: begin
                    if (etype == ETH_VLAN && !vlan_seen && !snap_seen) begin
                        state     <= L2_TAG_HI;
                        vlan_seen <= 1'b1;
                    end else if (etype == ETH_IPV4) begin
                        state <= L2_IP;
                    end else if (etype < ETH_MINTYPE && !snap_seen) begin
                        state <= L2_LLC;
                        cnt   <= '0;
                    end else begin
                        state <= L2_SKIP;
                    end
                end
                L2_TAG_HI: state <= byte_d[4] ? L2_SKIP : L2_TAG_LO;
                L2_TAG_LO: state <= L2_TYPE_HI;
                L2_LLC: begin
                    if (byte_d != snap_byte(cnt[2:0])) begin
                        state <= L2_SKIP;
                    end else begin
                        cnt <= cnt + 4'd1;
                        if (cnt == 4'd5) begin
                            snap_seen <= 1'b1;
                            state     <= L2_TYPE_HI;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxc_ip_walk.sv
// IPv4 and transport walker.
// Counts the bytes after the type field. It captures version/IHL, total
// length, fragment fields, protocol and the UDP checksum field. It feeds
// header words to one accumulator, and pseudo-header and segment words to a
// second one. Bytes past the IP total length are ignored.
// Assumes: ip_byte is high only for bytes after a 0x0800 type field.
module rxc_ip_walk #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sof,
    input  logic             ip_byte,
    input  logic [7:0]       byte_d,
    output logic [15:0]      ip_sum,
    output logic [15:0]      l4_sum,
    output logic             ver_ok,
    output logic [LEN_W-1:0] hdr_len,
    output logic [LEN_W-1:0] tot_len,
    output logic             frag,
    output logic [7:0]       proto,
    output logic             udp_cs_zero,
    output logic             hdr_done,
    output logic             l4_done
);
    import rxc_pkg::*;

    logic [LEN_W-1:0] pos, l4_off;
    logic [3:0]       ver, ihl;
    logic [7:0]       hi;
    logic             mf, off_hi_nz, off_lo_nz, cs_hi_z, cs_lo_z;
    logic             in_hdr, in_l4, last_l4;
    logic             ip_add, l4_add;
    logic [15:0]      ip_word, l4_word;

    assign hdr_len     = LEN_W'({ihl, 2'b00});
    assign ver_ok      = (ver == 4'd4) && (ihl >= 4'd5);
    assign frag        = mf || off_hi_nz || off_lo_nz;
    assign udp_cs_zero = cs_hi_z && cs_lo_z;
    assign l4_off      = pos - hdr_len;
    assign in_hdr      = (pos == '0) || (pos < hdr_len);
    assign in_l4       = (pos >= hdr_len) && (pos < tot_len) && (pos >= LEN_W'(20));
    assign last_l4     = (pos == tot_len - LEN_W'(1));

    // Pick the word (if any) that each accumulator takes this byte.
    always_comb begin
        ip_add  = 1'b0;
        ip_word = '0;
        l4_add  = 1'b0;
        l4_word = '0;
        if (ip_byte) begin
            if (pos[0] && in_hdr) begin
                ip_add  = 1'b1;
                ip_word = {hi, byte_d};
            end
            if (pos == LEN_W'(9)) begin
                l4_add  = 1'b1;
                l4_word = {8'h00, byte_d};
            end else if (pos[0] && pos >= LEN_W'(12) && pos <= LEN_W'(19)) begin
                l4_add  = 1'b1;
                l4_word = {hi, byte_d};
            end else if (in_l4 && pos[0]) begin
                l4_add  = 1'b1;
                l4_word = {hi, byte_d};
            end else if (in_l4 && last_l4) begin
                l4_add  = 1'b1;
                l4_word = {byte_d, 8'h00};
            end
        end
    end

    // Track the position and capture header fields.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_sof) begin
            pos       <= '0;
            ver       <= '0;
            ihl       <= '0;
            hi        <= '0;
            tot_len   <= '0;
            mf        <= 1'b0;
            off_hi_nz <= 1'b0;
            off_lo_nz <= 1'b0;
            proto     <= '0;
            cs_hi_z   <= 1'b0;
            cs_lo_z   <= 1'b0;
            hdr_done  <= 1'b0;
            l4_done   <= 1'b0;
        end else if (ip_byte) begin
            if (pos != '1) pos <= pos + LEN_W'(1);
            if (!pos[0]) hi <= byte_d;
            if (pos == LEN_W'(0)) begin
                ver <= byte_d[7:4];
                ihl <= byte_d[3:0];
            end
            if (pos == LEN_W'(2)) tot_len[LEN_W-1:8] <= byte_d[LEN_W-9:0];
            if (pos == LEN_W'(3)) tot_len[7:0] <= byte_d;
            if (pos == LEN_W'(6)) begin
                mf        <= byte_d[5];
                off_hi_nz <= (byte_d[4:0] != 5'd0);
            end
            if (pos == LEN_W'(7)) off_lo_nz <= (byte_d != 8'd0);
            if (pos == LEN_W'(9)) proto <= byte_d;
            if (pos != '0 && pos == hdr_len - LEN_W'(1)) hdr_done <= 1'b1;
            if (in_l4 && l4_off == LEN_W'(6)) cs_hi_z <= (byte_d == 8'd0);
            if (in_l4 && l4_off == LEN_W'(7)) cs_lo_z <= (byte_d == 8'd0);
            if (in_l4 && last_l4) l4_done <= 1'b1;
        end
    end

    rxc_ocsum #(.W(16)) u_ip_acc (
        .clk(clk), .rst_n(rst_n), .clr(frame_sof),
        .add(ip_add), .word(ip_word), .sum(ip_sum)
    );

    rxc_ocsum #(.W(16)) u_l4_acc (
        .clk(clk), .rst_n(rst_n), .clr(frame_sof),
        .add(l4_add), .word(l4_word), .sum(l4_sum)
    );

    // R6
    hdr_len_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && ver_ok) |-> (pos >= LEN_W'(20)));
endmodule

// File: rtl/rxc_csum_check.sv
// Receive checksum checker top.
// Latches the enable on each start byte and runs the L2 parser and the IP
// walker. One cycle after the end byte it folds the transport length into the
// segment sum and registers the verdict and the discard/count pulses.
// Assumes: frames do not overlap. A new start byte may follow the end byte at
// once.
module rxc_csum_check #(
    parameter int LEN_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [7:0] in_data,
    output logic       stat_valid,
    output logic       stat_ok,
    output logic       stat_bad,
    output logic [1:0] stat_kind,
    output logic       stat_snap,
    output logic       drop_pulse,
    output logic       cnt_inc_pulse
);
    import rxc_pkg::*;

    logic             frame_sof, frame_en, fin;
    logic             ip_byte, snap_seen;
    logic [15:0]      ip_sum, l4_sum, l4_final;
    logic             ver_ok, frag, udp_cs_zero, hdr_done, l4_done;
    logic [LEN_W-1:0] hdr_len, tot_len, l4_len;
    logic [7:0]       proto;
    logic             is_tcp, is_udp, hdr_elig, ip_good, l4_elig, l4_good, any_bad;
    kind_e            kind_n;

    assign frame_sof = in_valid && in_sof;

    rxc_l2_parse u_l2 (
        .clk(clk), .rst_n(rst_n), .byte_vld(in_valid), .byte_sof(in_sof),
        .byte_d(in_data), .ip_byte(ip_byte), .snap_seen(snap_seen)
    );

    rxc_ip_walk #(.LEN_W(LEN_W)) u_ip (
        .clk(clk), .rst_n(rst_n), .frame_sof(frame_sof), .ip_byte(ip_byte),
        .byte_d(in_data), .ip_sum(ip_sum), .l4_sum(l4_sum), .ver_ok(ver_ok),
        .hdr_len(hdr_len), .tot_len(tot_len), .frag(frag), .proto(proto),
        .udp_cs_zero(udp_cs_zero), .hdr_done(hdr_done), .l4_done(l4_done)
    );

    // Latch the enable on the start byte and mark the end byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_en <= 1'b0;
            fin      <= 1'b0;
        end else begin
            if (frame_sof) frame_en <= cfg_enable;
            fin <= in_valid && in_eof;
        end
    end

    // Decide which checks ran and whether they passed.
    always_comb begin
        is_tcp   = (proto == PROTO_TCP);
        is_udp   = (proto == PROTO_UDP);
        l4_len   = tot_len - hdr_len;
        l4_final = oc_add(l4_sum, 16'(l4_len));
        hdr_elig = frame_en && ver_ok && hdr_done && (tot_len >= hdr_len);
        ip_good  = (ip_sum == 16'hFFFF);
        l4_elig  = hdr_elig && ip_good && !frag && (is_tcp || is_udp) &&
                   (tot_len > hdr_len) && l4_done && !(is_udp && udp_cs_zero);
        l4_good  = (l4_final == 16'hFFFF);
        any_bad  = hdr_elig && (!ip_good || (l4_elig && !l4_good));
        if (!hdr_elig)    kind_n = KIND_NONE;
        else if (!l4_elig) kind_n = KIND_IPHDR;
        else if (is_tcp)  kind_n = KIND_TCP;
        else              kind_n = KIND_UDP;
    end

    // Register the verdict and the pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid    <= 1'b0;
            stat_ok       <= 1'b0;
            stat_bad      <= 1'b0;
            stat_kind     <= KIND_NONE;
            stat_snap     <= 1'b0;
            drop_pulse    <= 1'b0;
            cnt_inc_pulse <= 1'b0;
        end else begin
            stat_valid    <= fin;
            stat_ok       <= fin && (kind_n != KIND_NONE) && !any_bad;
            stat_bad      <= fin && any_bad;
            stat_kind     <= fin ? kind_n : KIND_NONE;
            stat_snap     <= fin && frame_en && snap_seen;
            drop_pulse    <= fin && any_bad;
            cnt_inc_pulse <= fin && any_bad;
        end
    end

    // R1
    stat_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(in_valid && in_eof, 2));

    // R9
    ok_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_ok && stat_bad));

    // R10
    drop_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pulse || cnt_inc_pulse) |-> (stat_valid && stat_bad));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !$past(frame_en)) |-> (stat_kind == 2'b00 && !stat_snap && !stat_bad));
endmodule

// File: tb/rxc_csum_check_test.sv
module rxc_csum_check_test;
    logic       clk = 1'b0;
    logic       rst_n, cfg_enable, in_valid, in_sof, in_eof;
    logic [7:0] in_data;
    logic       stat_valid, stat_ok, stat_bad, stat_snap, drop_pulse, cnt_inc_pulse;
    logic [1:0] stat_kind;

    always #4 clk = ~clk;

    rxc_csum_check uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .stat_valid(stat_valid), .stat_ok(stat_ok), .stat_bad(stat_bad),
        .stat_kind(stat_kind), .stat_snap(stat_snap), .drop_pulse(drop_pulse),
        .cnt_inc_pulse(cnt_inc_pulse)
    );

    int errors = 0, checks = 0;
    logic [7:0] frm [0:255];
    int flen;
    int o_vlan, o_cfi, o_snap, o_nonip, o_ver, o_ihl, o_proto, o_l4len;
    int o_frag, o_udpzero, o_cip, o_cl4, o_pad, o_trunc, o_en, o_gaps;

    task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic int unsigned fold(input int unsigned s);
        int unsigned r = s;
        while (r > 32'hFFFF) r = (r & 32'hFFFF) + (r >> 16);
        return r;
    endfunction

    task automatic put(input int b);
        frm[flen] = 8'(b);
        flen++;
    endtask

    task automatic defaults();
        o_vlan = 0; o_cfi = 0; o_snap = 0; o_nonip = 0; o_ver = 4; o_ihl = 5;
        o_proto = 6; o_l4len = 40; o_frag = 0; o_udpzero = 0; o_cip = 0;
        o_cl4 = 0; o_pad = 0; o_trunc = 0; o_en = 1; o_gaps = 0;
    endtask

    // Build one frame from the option set, with correct sums unless corrupted.
    task automatic build();
        int ipo, hl, tot, l4o, co;
        int unsigned s, cs;
        flen = 0;
        for (int i = 0; i < 12; i++) put(int'($urandom & 8'hFF));
        for (int v = 0; v < o_vlan; v++) begin
            put(8'h81); put(8'h00);
            put(int'(($urandom & 8'hEF) | ((v == 0 && o_cfi != 0) ? 8'h10 : 8'h00)));
            put(int'($urandom & 8'hFF));
        end
        if (o_snap != 0) begin
            put(8'h00); put(8'h40);
            put(o_snap == 2 ? 8'h42 : 8'hAA); put(8'hAA); put(8'h03);
            put(8'h00); put(8'h00); put(8'h00);
        end
        put(8'h08); put(o_nonip != 0 ? 8'h06 : 8'h00);
        ipo = flen;
        hl  = o_ihl * 4;
        tot = hl + o_l4len;
        put(((o_ver & 15) << 4) | (o_ihl & 15));
        put(int'($urandom & 8'hFF));
        put(tot >> 8); put(tot & 8'hFF);
        put(int'($urandom & 8'hFF)); put(int'($urandom & 8'hFF));
        if (o_frag == 1)      begin put(8'h20); put(8'h00); end
        else if (o_frag == 2) begin put(8'h00); put(8'h10); end
        else                  begin put(int'($urandom & 8'h40)); put(8'h00); end
        put(int'($urandom & 8'hFF)); put(o_proto); put(0); put(0);
        for (int i = 0; i < 8; i++) put(int'($urandom & 8'hFF));
        for (int i = 20; i < hl; i++) put(int'($urandom & 8'hFF));
        s = 0;
        for (int i = 0; i + 1 < hl; i += 2) s += {frm[ipo+i], frm[ipo+i+1]};
        cs = ~fold(s) & 32'hFFFF;
        frm[ipo+10] = 8'(cs >> 8);
        frm[ipo+11] = 8'(cs);
        l4o = flen;
        for (int i = 0; i < o_l4len; i++) put(int'($urandom & 8'hFF));
        co = (o_proto == 6) ? 16 : (o_proto == 17) ? 6 : -1;
        if (co >= 0) begin
            frm[l4o+co] = 8'h00;
            frm[l4o+co+1] = 8'h00;
            s = 32'(o_proto) + 32'(o_l4len);
            for (int i = 12; i < 20; i += 2) s += {frm[ipo+i], frm[ipo+i+1]};
            for (int i = 0; i < o_l4len; i += 2)
                s += {frm[l4o+i], (i + 1 < o_l4len) ? frm[l4o+i+1] : 8'h00};
            cs = ~fold(s) & 32'hFFFF;
            if (o_proto == 17 && cs == 0) cs = 32'hFFFF;
            if (o_proto == 17 && o_udpzero != 0) cs = 0;
            frm[l4o+co]   = 8'(cs >> 8);
            frm[l4o+co+1] = 8'(cs);
        end
        if (o_cip != 0) frm[ipo+8] = frm[ipo+8] ^ 8'h01;
        if (o_cl4 != 0) frm[l4o+4] = frm[l4o+4] ^ 8'h10;
        for (int i = 0; i < o_pad; i++) put(int'($urandom & 8'hFF));
        if (o_trunc == 1) flen = ipo + 10;
        if (o_trunc == 2) flen = ipo + tot - 1;
    endtask

    // Drive one frame, then check the verdict timing and contents.
    task automatic run_frame(input string tag);
        logic hdr_elig, l4_elig, e_bad, e_snap, e_ok;
        logic [1:0] e_kind;
        build();
        hdr_elig = (o_en != 0) && (o_nonip == 0) && (o_vlan <= 1) &&
                   !(o_vlan == 1 && o_cfi != 0) && (o_snap != 2) &&
                   (o_ver == 4) && (o_ihl >= 5) && (o_trunc != 1);
        l4_elig  = hdr_elig && (o_cip == 0) && (o_frag == 0) &&
                   (o_proto == 6 || o_proto == 17) && (o_trunc != 2) &&
                   !(o_proto == 17 && o_udpzero != 0);
        e_kind = !hdr_elig ? 2'b00 : !l4_elig ? 2'b01 : (o_proto == 6) ? 2'b10 : 2'b11;
        e_bad  = hdr_elig && ((o_cip != 0) || (l4_elig && o_cl4 != 0));
        e_ok   = (e_kind != 2'b00) && !e_bad;
        e_snap = (o_en != 0) && (o_snap == 1) && (o_vlan <= 1) && !(o_vlan == 1 && o_cfi != 0);
        cfg_enable = (o_en != 0);
        for (int i = 0; i < flen; i++) begin
            if (o_gaps != 0 && ($urandom % 4) == 0) begin
                in_valid = 1'b0;
                @(posedge clk); @(negedge clk);
            end
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == flen - 1);
            in_data  = frm[i];
            @(posedge clk); @(negedge clk);
            if (i == 0) cfg_enable = 1'($urandom & 1);   // R11: ignored mid-frame
            chk({tag, " R10 no pulse mid-frame"}, {31'd0, drop_pulse}, 32'd0);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        chk({tag, " R1 verdict not early"}, {31'd0, stat_valid}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk({tag, " R1 verdict valid"}, {31'd0, stat_valid}, 32'd1);
        chk({tag, " R9 kind"}, {30'd0, stat_kind}, {30'd0, e_kind});
        chk({tag, " R2 ok/bad"}, {30'd0, stat_ok, stat_bad}, {30'd0, e_ok, e_bad});
        chk({tag, " R5 snap"}, {31'd0, stat_snap}, {31'd0, e_snap});
        chk({tag, " R10 pulses"}, {30'd0, drop_pulse, cnt_inc_pulse}, {30'd0, e_bad, e_bad});
        @(posedge clk); @(negedge clk);
        chk({tag, " R1 single pulse"}, {30'd0, stat_valid, drop_pulse}, 32'd0);
    endtask

    task automatic rand_opts();
        defaults();
        o_vlan    = ($urandom % 4 == 0) ? (($urandom % 5 == 0) ? 2 : 1) : 0;
        o_cfi     = (o_vlan != 0 && $urandom % 6 == 0) ? 1 : 0;
        o_snap    = ($urandom % 4 == 0) ? (($urandom % 5 == 0) ? 2 : 1) : 0;
        o_nonip   = ($urandom % 12 == 0) ? 1 : 0;
        o_ver     = ($urandom % 15 == 0) ? 6 : 4;
        o_ihl     = ($urandom % 10 == 0) ? int'($urandom % 5) :
                    5 + (($urandom % 3 == 0) ? int'($urandom % 11) : 0);
        case ($urandom % 3)
            0:       o_proto = 6;
            1:       o_proto = 17;
            default: o_proto = 1;
        endcase
        o_l4len   = ((o_proto == 6) ? 20 : (o_proto == 17) ? 8 : 4) + int'($urandom % 40);
        o_frag    = ($urandom % 8 == 0) ? 1 + int'($urandom % 2) : 0;
        o_udpzero = ($urandom % 8 == 0) ? 1 : 0;
        o_cip     = ($urandom % 8 == 0) ? 1 : 0;
        o_cl4     = ($urandom % 6 == 0) ? 1 : 0;
        o_pad     = int'($urandom % 6);
        o_trunc   = ($urandom % 15 == 0) ? 1 + int'($urandom % 2) : 0;
        o_en      = ($urandom % 10 != 0) ? 1 : 0;
        o_gaps    = int'($urandom % 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_enable = 1'b0; in_valid = 1'b0;
        in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset state", {25'd0, stat_valid, stat_ok, stat_bad, stat_kind,
            stat_snap, drop_pulse, cnt_inc_pulse}, 32'd0);
        @(negedge clk);

        defaults();                                   run_frame("R3 clean TCP");
        defaults(); o_proto = 17; o_l4len = 27; o_pad = 5; run_frame("R3 odd UDP with pad");
        defaults(); o_proto = 17; o_udpzero = 1;      run_frame("R8 UDP zero field");
        defaults(); o_cip = 1;                        run_frame("R2 bad header");
        defaults(); o_cl4 = 1;                        run_frame("R3 bad TCP");
        defaults(); o_vlan = 1; o_cfi = 1;            run_frame("R4 CFI set");
        defaults(); o_vlan = 2;                       run_frame("R4 double tag");
        defaults(); o_vlan = 1; o_proto = 17;         run_frame("R4 single tag");
        defaults(); o_snap = 1; o_vlan = 1;           run_frame("R5 SNAP");
        defaults(); o_snap = 2;                       run_frame("R5 other LLC");
        defaults(); o_frag = 1;                       run_frame("R7 MF set");
        defaults(); o_frag = 2;                       run_frame("R7 offset set");
        defaults(); o_proto = 1;                      run_frame("R7 other protocol");
        defaults(); o_ihl = 15; o_proto = 17;         run_frame("R6 IHL 15");
        defaults(); o_ihl = 4;                        run_frame("R6 IHL 4");
        defaults(); o_ver = 6;                        run_frame("R6 version 6");
        defaults(); o_trunc = 1;                      run_frame("R6 cut header");
        defaults(); o_trunc = 2;                      run_frame("R7 cut segment");
        defaults(); o_en = 0; o_cip = 1; o_snap = 1;  run_frame("R11 disabled");
        defaults(); o_gaps = 1; o_cl4 = 1; o_proto = 17; run_frame("R10 bad UDP gaps");

        for (int n = 0; n < 180; n++) begin
            rand_opts();
            run_frame("random");
        end

        summary();
        $finish;
    end
endmodule